// File: doc/BRIEF.md
# Scan-Testable Derived Clock, Derived Clear and Feedback Loop

This block is a small piece of functional logic whose internal clocking and clearing make it hard to test with scan, along with the changes that make it testable. A toggle flop divides the pin clock, and a multi-bit capture register runs off that divided clock. A sticky activity flag has an asynchronous clear driven by a registered clear request. A combinational hold loop (set / keep) drives a level output. A single scan-test-mode pin changes all three. The capture register moves onto the pin clock, with lockup latches on both sides of it in the scan order. The flag's clear comes from the reset pin alone. The hold loop takes its feedback from a dedicated break register instead of from itself.

With test mode low, the block behaves cycle for cycle like the unmodified design, and the scan pins have no effect. With test mode high and scan enable high, every flop forms one serial shift path from `scan_in` to `scan_out`. With test mode high and scan enable low, every flop captures its functional next value on the pin clock.

Two parameters choose the weaker fallbacks. With the first, the capture register is held cleared for the whole of test mode and is left out of the shift path. With the second, the loop feedback is a constant 0 in test mode and no break register is built. The control pins are plain levels. There is no streaming handshake, because nothing here moves data under flow control.

Top module: `testable_clkrst_core`

## Requirements
- R1: With `test_mode` low, the divider flop toggles on every rising `clk` edge (0 after reset). The capture register `slow_q` loads `data_in` only on edges where the divider goes from 0 to 1, which are the 1st, 3rd, 5th and later odd edges after reset is released. It holds on all other edges.
- R2: With `test_mode` low, `flag_q` becomes 1 at any `clk` edge where `data_in` is nonzero. `clear_req` is registered on each edge. `flag_q` is cleared asynchronously, and held at 0, for as long as that registered request is 1.
- R3: With `test_mode` low, `loop_q` = `loop_set` OR (`loop_keep` AND held value). The held value follows `loop_q`, so `loop_set` drives 1, `loop_keep` alone holds the last level, and `loop_keep` low with `loop_set` low gives 0. This responds combinationally, with no clock.
- R4: With `test_mode` high, the capture register is clocked by the pin clock on every edge, and a capture edge loads `data_in` into it.
- R5: With `test_mode` high, only `rst_n` clears `flag_q`. A registered clear request of 1 has no effect.
- R6: With `test_mode` high, `loop_q` = `loop_set` OR (`loop_keep` AND break register). On each capture edge the break register loads `loop_q`. In the constant fallback, the feedback term is 0.
- R7: When `test_mode` and `scan_en` are both high, each `clk` edge moves the data one place along this order, and a pattern comes out of `scan_out` unchanged after chain-length edges:
  - `scan_in`, then the divider;
  - `slow_q[0]` through `slow_q[W-1]`;
  - the registered clear request, then `flag_q`;
  - the break register, which drives `scan_out`.
  The lockup latches add no cycle. The default chain length is W+4. With both fallbacks it is 3 (divider, clear request, flag).
- R8: With `test_mode` low, `scan_en` and `scan_in` have no effect on `slow_q` or `flag_q`.
- R9: `rst_n` low clears every flop and the loop hold in either mode, at once and without a clock edge.
- R10: In the re-clock fallback, `slow_q` stays 0 throughout test mode whatever `data_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin clock; the scan clock in test mode |
| rst_n | input | 1 | Active-low asynchronous reset pin |
| test_mode | input | 1 | Scan-test mode select |
| scan_en | input | 1 | Shift (1) or capture (0) while in test mode |
| scan_in | input | 1 | Serial scan data in |
| data_in | input | W | Functional data sampled by the capture register and the flag |
| clear_req | input | 1 | Functional request to clear the flag |
| loop_set | input | 1 | Sets the feedback loop output |
| loop_keep | input | 1 | Lets the loop hold its level |
| scan_out | output | 1 | Serial scan data out |
| slow_q | output | W | Capture register contents |
| flag_q | output | 1 | Sticky activity flag |
| loop_q | output | 1 | Feedback loop output |

## Verification
The bench builds two copies side by side. The first uses W=4 with both test-time fixes, which gives an 8-stage chain. The second uses W=4 with both fallbacks, which gives a 3-stage chain. Both share every input pin, so one stimulus stream checks the full-fix and fallback behaviour against each other.

With a 4-bit capture register, a 32-step capture sweep covers every data value. The same sweep reaches every combination of the loop inputs with both break-register levels, and every flag and clear-request level loaded through the chain. Each result is read back through `scan_out` and compared with a vector the bench works out by arithmetic.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  // Which clock drives the capture register.
  typedef enum logic {
    CLK_SRC_DERIVED = 1'b0,
    CLK_SRC_PIN     = 1'b1
  } clk_src_e;
endpackage

// File: rtl/tcr_sdff.sv
// Scan flop: asynchronous clear only (never set and clear on one cell).
module tcr_sdff (
  input  logic clk,
  input  logic clr_n,
  input  logic shift,
  input  logic si,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= shift ? si : d;
  end
endmodule

// File: rtl/tcr_lockup.sv
// Lockup latch: open while the clock is low, closed through the high phase,
// so the next stage still sees the pre-edge value if its clock arrives late.
module tcr_lockup (
  input  logic clk,
  input  logic d,
  output logic q
);
  always_latch begin
    if (!clk) q <= d;
  end
endmodule

// File: rtl/tcr_div_stage.sv
// Divider flop plus the register it clocks.
module tcr_div_stage #(
  parameter int unsigned W       = 4,
  parameter bit          RECLOCK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         shift,
  input  logic         si,
  input  logic [W-1:0] din,
  output logic         div_q,
  output logic [W-1:0] slow_q,
  output logic         so
);
  import tcr_pkg::*;

  logic         slow_clk;
  logic         slow_clr_n;
  logic [W-1:0] slow_d;

  // Divide-by-two toggle flop, first element of the chain.
  tcr_sdff u_div (
    .clk   (clk),
    .clr_n (rst_n),
    .shift (shift),
    .si    (si),
    .d     (~div_q),
    .q     (div_q)
  );

  generate
    if (RECLOCK) begin : g_reclock
      clk_src_e   src;
      logic       lk_in_q;
      logic       lk_out_q;
      logic [W:0] sh_vec;

      // Test mode swaps the derived clock for the pin clock.
      assign src      = test_mode ? CLK_SRC_PIN : CLK_SRC_DERIVED;
      assign slow_clk = (src == CLK_SRC_PIN) ? clk : div_q;
      assign slow_clr_n = rst_n;

      // Lockup latch ahead of the re-clocked register.
      tcr_lockup u_lk_in (
        .clk (clk),
        .d   (div_q),
        .q   (lk_in_q)
      );

      assign sh_vec = {slow_q, lk_in_q};
      assign slow_d = shift ? sh_vec[W-1:0] : din;

      // Lockup latch behind it.
      tcr_lockup u_lk_out (
        .clk (clk),
        .d   (slow_q[W-1]),
        .q   (lk_out_q)
      );

      assign so = lk_out_q;
    end else begin : g_hold
      // Fallback: keep the derived clock but hold the register cleared
      // for the whole of test mode; it drops out of the chain.
      assign slow_clk   = div_q;
      assign slow_clr_n = rst_n & ~test_mode;
      assign slow_d     = din;
      assign so         = div_q;
    end
  endgenerate

  always_ff @(posedge slow_clk or negedge slow_clr_n) begin
    if (!slow_clr_n) slow_q <= '0;
    else             slow_q <= slow_d;
  end
endmodule

// File: rtl/tcr_clear_stage.sv
// Sticky flag whose asynchronous clear comes from a registered request.
module tcr_clear_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         shift,
  input  logic         si,
  input  logic [W-1:0] din,
  input  logic         clear_req,
  output logic         clr_q,
  output logic         flag_q
);
  logic flag_clr_n;

  tcr_sdff u_clr (
    .clk   (clk),
    .clr_n (rst_n),
    .shift (shift),
    .si    (si),
    .d     (clear_req),
    .q     (clr_q)
  );

  // In test mode only the reset pin may reach the clear input.
  assign flag_clr_n = test_mode ? rst_n : (rst_n & ~clr_q);

  tcr_sdff u_flag (
    .clk   (clk),
    .clr_n (flag_clr_n),
    .shift (shift),
    .si    (clr_q),
    .d     (flag_q | (|din)),
    .q     (flag_q)
  );
endmodule

// File: rtl/tcr_loop_stage.sv
// Set/keep hold loop. The functional hold is written as an explicit level
// element so the model has no zero-delay cycle; test mode replaces the
// feedback with a break register or a constant.
module tcr_loop_stage #(
  parameter bit BREAK_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic shift,
  input  logic si,
  input  logic loop_set,
  input  logic loop_keep,
  output logic loop_q,
  output logic so
);
  logic hold_q;
  logic fb;
  logic brk_term;

  // Functional hold: follows loop_q whenever the loop is not keeping.
  always_latch begin
    if (!rst_n)                                   hold_q <= 1'b0;
    else if (!test_mode && (loop_set || !loop_keep)) hold_q <= loop_set;
  end

  generate
    if (BREAK_REG) begin : g_brk_reg
      logic brk_q;
      tcr_sdff u_brk (
        .clk   (clk),
        .clr_n (rst_n),
        .shift (shift),
        .si    (si),
        .d     (loop_q),
        .q     (brk_q)
      );
      assign brk_term = brk_q;
      assign so       = brk_q;
    end else begin : g_brk_const
      logic unused_loop_pins;
      assign unused_loop_pins = clk ^ shift;
      assign brk_term = 1'b0;
      assign so       = si;
    end
  endgenerate

  assign fb     = test_mode ? brk_term : hold_q;
  assign loop_q = loop_set | (loop_keep & fb);
endmodule

// File: rtl/testable_clkrst_core.sv
module testable_clkrst_core #(
  parameter int unsigned W         = 4,
  parameter bit          RECLOCK   = 1'b1,
  parameter bit          BREAK_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic [W-1:0] data_in,
  input  logic         clear_req,
  input  logic         loop_set,
  input  logic         loop_keep,
  output logic         scan_out,
  output logic [W-1:0] slow_q,
  output logic         flag_q,
  output logic         loop_q
);
  logic shift;
  logic div_q_w;
  logic clr_q_w;
  logic div_so;

  // Shifting needs both pins; scan_en alone does nothing in functional mode.
  assign shift = test_mode & scan_en;

  tcr_div_stage #(.W(W), .RECLOCK(RECLOCK)) u_div_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .shift     (shift),
    .si        (scan_in),
    .din       (data_in),
    .div_q     (div_q_w),
    .slow_q    (slow_q),
    .so        (div_so)
  );

  tcr_clear_stage #(.W(W)) u_clear_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .shift     (shift),
    .si        (div_so),
    .din       (data_in),
    .clear_req (clear_req),
    .clr_q     (clr_q_w),
    .flag_q    (flag_q)
  );

  tcr_loop_stage #(.BREAK_REG(BREAK_REG)) u_loop_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .shift     (shift),
    .si        (flag_q),
    .loop_set  (loop_set),
    .loop_keep (loop_keep),
    .loop_q    (loop_q),
    .so        (scan_out)
  );
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int unsigned W       = 4,
  parameter bit          RECLOCK = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_mode,
  input logic         scan_en,
  input logic         scan_in,
  input logic         div_q,
  input logic         clr_q,
  input logic         flag_q,
  input logic [W-1:0] slow_q,
  input logic         loop_set,
  input logic         loop_keep,
  input logic         loop_q
);
  // R7: the first chain stage takes scan_in on a shift edge.
  p_shift_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && scan_en) |=> (div_q == $past(scan_in)));

  // R2: a registered clear request keeps the flag at 0 in functional mode.
  p_flag_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && clr_q) |-> !flag_q);

  // R5: in capture, the flag is never lost while test mode stays on.
  p_flag_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !scan_en && flag_q) |=> (flag_q || !test_mode));

  // R1: an edge on which the divider falls leaves the capture register alone.
  p_slow_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && div_q) |=> (test_mode || $stable(slow_q)));

  // R6: with neither loop input, no feedback path can raise the output.
  p_loop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !loop_set && !loop_keep) |-> !loop_q);

  generate
    if (!RECLOCK) begin : g_fallback
      // R10: held cleared for the whole of test mode.
      p_slow_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (slow_q == '0));
    end
  endgenerate
endmodule

bind testable_clkrst_core tcr_checker #(.W(W), .RECLOCK(RECLOCK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .scan_en   (scan_en),
  .scan_in   (scan_in),
  .div_q     (div_q_w),
  .clr_q     (clr_q_w),
  .flag_q    (flag_q),
  .slow_q    (slow_q),
  .loop_set  (loop_set),
  .loop_keep (loop_keep),
  .loop_q    (loop_q)
);

// File: tb/testable_clkrst_core_test.sv
`timescale 1ns/1ps
module testable_clkrst_core_test;
  localparam int W  = 4;
  localparam int N  = W + 4;   // chain length, full-fix build
  localparam int NA = 3;       // chain length, fallback build

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic clear_req = 1'b0;
  logic loop_set = 1'b0;
  logic loop_keep = 1'b0;

  logic scan_out, flag_q, loop_q;
  logic [W-1:0] slow_q;
  logic a_scan_out, a_flag_q, a_loop_q;
  logic [W-1:0] a_slow_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  testable_clkrst_core #(.W(W), .RECLOCK(1'b1), .BREAK_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
    .scan_in(scan_in), .data_in(data_in), .clear_req(clear_req),
    .loop_set(loop_set), .loop_keep(loop_keep), .scan_out(scan_out),
    .slow_q(slow_q), .flag_q(flag_q), .loop_q(loop_q));

  testable_clkrst_core #(.W(W), .RECLOCK(1'b0), .BREAK_REG(1'b0)) uut_alt (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_en(scan_en),
    .scan_in(scan_in), .data_in(data_in), .clear_req(clear_req),
    .loop_set(loop_set), .loop_keep(loop_keep), .scan_out(a_scan_out),
    .slow_q(a_slow_q), .flag_q(a_flag_q), .loop_q(a_loop_q));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance to 2 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic bit pat(input int i);
    return ((i * 5 + 1) % 7) < 3;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       div_m, clr_m, flag_m, old_clr;
    logic [W-1:0] slow_m;
    logic [N-1:0] s, e, got;

    // ---------------- reset state (R9)
    repeat (3) step();
    chk(slow_q == 0,   "R9 reset slow_q", slow_q, 0);
    chk(flag_q == 0,   "R9 reset flag_q", flag_q, 0);
    chk(loop_q == 0,   "R9 reset loop_q", loop_q, 0);
    chk(scan_out == 0, "R9 reset scan_out", scan_out, 0);
    chk(a_slow_q == 0, "R9 reset fallback slow_q", a_slow_q, 0);
    rst_n = 1'b1;

    // ---------------- functional sweep (R1, R2, R8)
    div_m = 0; clr_m = 0; flag_m = 0; slow_m = '0;
    for (int k = 1; k <= 48; k++) begin
      data_in   = W'((k * 7 + 3) % 16);
      if (k % 9 == 0) data_in = '0;
      scan_en   = k[0];
      scan_in   = k[1];
      clear_req = (k % 10 == 7) || (k % 10 == 8);
      step();
      div_m = ~div_m;
      if (div_m) slow_m = data_in;
      old_clr = clr_m;
      clr_m   = clear_req;
      flag_m  = old_clr ? 1'b0 : (flag_m | (data_in != 0));
      if (clr_m) flag_m = 1'b0;
      chk(slow_q == slow_m, "R1 R8 divided capture", slow_q, slow_m);
      chk(flag_q == flag_m, "R2 R8 flag", flag_q, flag_m);
      chk(a_slow_q == slow_m, "R1 fallback divided capture", a_slow_q, slow_m);
      chk(a_flag_q == flag_m, "R2 fallback flag", a_flag_q, flag_m);
    end
    clear_req = 0; scan_en = 0; scan_in = 0;

    // ---------------- functional loop (R3)
    loop_set = 1; loop_keep = 1; #1;
    chk(loop_q == 1, "R3 set", loop_q, 1);
    loop_set = 0; #1;
    chk(loop_q == 1, "R3 keep holds 1", loop_q, 1);
    chk(a_loop_q == 1, "R3 fallback keep holds 1", a_loop_q, 1);
    step();
    chk(loop_q == 1, "R3 hold across clock", loop_q, 1);
    loop_keep = 0; #1;
    chk(loop_q == 0, "R3 release", loop_q, 0);
    loop_keep = 1; #1;
    chk(loop_q == 0, "R3 keep holds 0", loop_q, 0);
    loop_keep = 0;

    // ---------------- scan shift (R7)
    step();
    test_mode = 1; scan_en = 1;
    scan_in = pat(0);
    for (int i = 0; i < 3 * N; i++) begin
      step();
      if (i >= N - 1)
        chk(scan_out == pat(i - N + 1), "R7 chain shift", scan_out, pat(i - N + 1));
      if (i >= NA - 1)
        chk(a_scan_out == pat(i - NA + 1), "R7 fallback chain shift", a_scan_out, pat(i - NA + 1));
      chk(a_slow_q == 0, "R10 held in test mode", a_slow_q, 0);
      scan_in = pat(i + 1);
    end

    // ---------------- capture sweep (R4, R5, R6, R10)
    for (int t = 0; t < 32; t++) begin
      s = N'((t * 37 + 11) & 8'hFF);
      if (t % 4 == 1) s[W+1] = 1'b1;      // clear request loaded high
      if (t % 4 == 1) s[W+2] = 1'b1;      // flag loaded high
      scan_en = 1;
      for (int k = N - 1; k >= 0; k--) begin
        scan_in = s[k];
        step();
      end
      scan_en   = 0;
      data_in   = W'(t % 16);
      clear_req = t[2];
      loop_set  = (t % 3 == 0);
      loop_keep = t[0] ^ t[3];
      #1;
      chk(loop_q == (loop_set | (loop_keep & s[W+3])), "R6 break register feedback",
          loop_q, loop_set | (loop_keep & s[W+3]));
      chk(a_loop_q == loop_set, "R6 constant feedback", a_loop_q, loop_set);
      e[0]       = ~s[0];
      e[W:1]     = data_in;
      e[W+1]     = clear_req;
      e[W+2]     = s[W+2] | (data_in != 0);
      e[W+3]     = loop_set | (loop_keep & s[W+3]);
      step();
      chk(slow_q == data_in, "R4 pin-clock capture", slow_q, data_in);
      chk(a_slow_q == 0, "R10 held through capture", a_slow_q, 0);
      if (s[W+2] && s[W+1])
        chk(flag_q == 1, "R5 clear request ignored", flag_q, 1);
      scan_en = 1; loop_set = 0; loop_keep = 0; clear_req = 0;
      for (int j = 0; j < N; j++) begin
        got[N-1-j] = scan_out;
        if (j < N - 1) step();
      end
      chk(got == e, "R4 R5 R6 captured chain", got, e);
    end

    // ---------------- reset in test mode (R9)
    scan_en = 1; scan_in = 1; data_in = '1;
    for (int k = 0; k < N; k++) step();
    rst_n = 0; #1;
    chk(slow_q == 0,   "R9 test-mode reset slow_q", slow_q, 0);
    chk(flag_q == 0,   "R9 test-mode reset flag_q", flag_q, 0);
    chk(scan_out == 0, "R9 test-mode reset scan_out", scan_out, 0);
    step();
    test_mode = 0; scan_en = 0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule